// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block is the digital control for one winding of a full H-bridge. It regulates winding current by fixed off-time chopping. Each on phase turns on one diagonal of the bridge, chosen by the direction bit. An external comparator raises a trip bit when the sensed current reaches its reference. The block ignores that bit for a blanking interval at the start of every on phase. After that interval a trip ends the on phase and starts an off phase of fixed length. During the off phase the bridge runs in either fast or slow decay.

A two-bit mode input selects how the off phase behaves. Two of the modes use a built-in off length and mixed decay, and both fall back to slow decay while the driver runs in full-step mode. The third mode takes its off length from an input word and always uses mixed decay. A short-to-ground indication latches the bridge off until the sleep input is released or reset is applied. A shorted load needs no special path: the normal trip and off-time loop keeps repeating. While sleep is asserted the bridge is dark and the controller waits in idle.

Top module: `chopper_ctrl`

## Requirements
- R1: After reset, with sleep low and no fault, an on phase starts on the first clock edge. gate_o holds the bits {high A, low A, high B, low B}. During an on phase gate_o is 4'b1001 when the latched direction is 1 and 4'b0110 when it is 0, and decay_o is 2'b00.
- R2: dir_i is sampled only on the clock edge that starts an on phase. A change during an on or off phase has no effect until the next on phase.
- R3: trip_i is ignored during on-phase cycles 0 to BLANK_CYCLES-1. If trip_i is high in on-phase cycle BLANK_CYCLES or any later on-phase cycle, the next cycle is the first off cycle.
- R4: The off phase lasts exactly L cycles, and the cycle after it is on-phase cycle 0. L is OFF_CYCLES_DEFAULT for mode_i 2'b00 and 2'b01. For mode_i 2'b10 and 2'b11, L is off_ext_i sampled at the trip, with 0 treated as 1.
- R5: Mixed decay makes off cycles 0 to floor(L/3)-1 fast: the opposite diagonal is on (4'b0110 for direction 1, 4'b1001 for direction 0) and decay_o is 2'b01. The remaining off cycles are slow: only the low switch of the active diagonal is on (4'b0001 for direction 1, 4'b0100 for direction 0) and decay_o is 2'b10.
- R6: If full_step_i is high at the trip and mode_i is 2'b00 or 2'b01, the whole off phase is slow decay. With mode_i 2'b10 or 2'b11, decay is mixed whatever full_step_i is.
- R7: With trip_i held high, the block repeats BLANK_CYCLES+1 on cycles followed by L off cycles.
- R8: gnd_short_i high while sleep_i is low sets a fault. From the next cycle gate_o is 0 and stays 0 whatever trip_i, dir_i or mode_i do, until a wake transition or reset.
- R9: A falling edge on sleep_i (wake) clears the fault. The next clock edge starts on-phase cycle 0.
- R10: While sleep_i is high, gate_o and decay_o are 0 in that same cycle and gnd_short_i is ignored.
- R11: gate_o never turns on the high and low switch of the same half-bridge together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trip_i | input | 1 | Current comparator trip |
| mode_i | input | 2 | Off-time and decay mode select |
| full_step_i | input | 1 | Driver is in full-step mode |
| gnd_short_i | input | 1 | Short-to-ground detect |
| dir_i | input | 1 | Current direction |
| sleep_i | input | 1 | Sleep request, high = asleep |
| off_ext_i | input | OFF_W | Off length in cycles for the external modes |
| gate_o | output | 4 | Bridge gate enables {high A, low A, high B, low B} |
| decay_o | output | 2 | 00 driving or idle, 01 fast, 10 slow |

## Verification
Any fault in the phase counters shows on gate_o at the first phase boundary after it. A wrong blanking count moves the first off cycle one or more cycles away from where a trip after blanking should put it. A wrong off counter changes the number of off cycles, and a wrong fast-decay limit moves the point where the gate pattern switches from the opposite diagonal to the single low switch. A wrongly latched direction or decay choice shows up as a wrong gate pattern in the very first cycle that uses it. A fault latch that clears too early lets a diagonal turn on while the bridge should still be dark.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ON   = 2'b01,
    ST_OFF  = 2'b10
  } chop_state_e;

  typedef enum logic [1:0] {
    DCY_NONE = 2'b00,
    DCY_FAST = 2'b01,
    DCY_SLOW = 2'b10
  } decay_e;

  // gate bit order {hi_a, lo_a, hi_b, lo_b}
  function automatic logic [3:0] drive_pat(input logic dir);
    return dir ? 4'b1001 : 4'b0110;
  endfunction

  function automatic logic [3:0] fast_pat(input logic dir);
    return dir ? 4'b0110 : 4'b1001;
  endfunction

  function automatic logic [3:0] slow_pat(input logic dir);
    return dir ? 4'b0001 : 4'b0100;
  endfunction
endpackage

// File: rtl/chop_blank.sv
module chop_blank #(
  parameter int BLANK_CYCLES = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic open_o
);
  localparam int BW = (BLANK_CYCLES < 1) ? 1 : $clog2(BLANK_CYCLES + 1);
  localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_CYCLES);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (start_i)                cnt_q <= BLANK_LD;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign open_o = (cnt_q == '0);

  AST_BLANK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= BLANK_LD);  // R3
  AST_BLANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && BLANK_CYCLES > 0) |=> !open_o);  // R3
endmodule

// File: rtl/chop_offtimer.sv
module chop_offtimer #(
  parameter int OFF_W              = 16,
  parameter int OFF_CYCLES_DEFAULT = 7500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             ext_sel_i,
  input  logic [OFF_W-1:0] off_ext_i,
  output logic             last_o,
  output logic             fast_o
);
  localparam logic [OFF_W-1:0] DEF_LEN = OFF_W'(OFF_CYCLES_DEFAULT);
  localparam logic [OFF_W-1:0] ONE     = OFF_W'(1);
  localparam logic [OFF_W-1:0] THREE   = OFF_W'(3);

  logic [OFF_W-1:0] len_d, len_q, fast_q, cnt_q;

  always_comb begin
    if (ext_sel_i) len_d = (off_ext_i == '0) ? ONE : off_ext_i;
    else           len_d = DEF_LEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= ONE;
      fast_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      len_q  <= len_d;
      fast_q <= len_d / THREE;
      cnt_q  <= '0;
    end else if (run_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == len_q - ONE);
  assign fast_o = (cnt_q < fast_q);

  AST_OFF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < len_q);  // R4
  AST_FAST_SHARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_q <= len_q);  // R5
endmodule

// File: rtl/chop_fault.sv
module chop_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic short_i,
  input  logic sleep_i,
  output logic fault_o,
  output logic fault_next_o
);
  logic sleep_q, fault_q, wake;

  assign wake         = sleep_q & ~sleep_i;
  assign fault_next_o = (fault_q & ~wake) | (short_i & ~sleep_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      sleep_q <= sleep_i;
      fault_q <= fault_next_o;
    end
  end

  assign fault_o = fault_q;

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !(sleep_q && !sleep_i)) |=> fault_q);  // R8
  AST_FAULT_SLEEP_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_q && sleep_i) |=> !fault_q);  // R10
endmodule

// File: rtl/chop_bridge.sv
module chop_bridge
  import chop_pkg::*;
(
  input  chop_state_e state_i,
  input  logic        dir_i,
  input  logic        fast_i,
  input  logic        slow_only_i,
  input  logic        sleep_i,
  input  logic        fault_i,
  output logic [3:0]  gate_o,
  output decay_e      decay_o
);
  always_comb begin
    gate_o  = 4'b0000;
    decay_o = DCY_NONE;
    if (!sleep_i && !fault_i) begin
      unique case (state_i)
        ST_ON: gate_o = drive_pat(dir_i);
        ST_OFF: begin
          if (fast_i && !slow_only_i) begin
            gate_o  = fast_pat(dir_i);
            decay_o = DCY_FAST;
          end else begin
            gate_o  = slow_pat(dir_i);
            decay_o = DCY_SLOW;
          end
        end
        default: gate_o = 4'b0000;
      endcase
    end
  end
endmodule

// File: rtl/chopper_ctrl.sv
module chopper_ctrl
  import chop_pkg::*;
#(
  parameter int BLANK_CYCLES       = 250,
  parameter int OFF_CYCLES_DEFAULT = 7500,
  parameter int OFF_W              = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trip_i,
  input  logic [1:0]       mode_i,
  input  logic             full_step_i,
  input  logic             gnd_short_i,
  input  logic             dir_i,
  input  logic             sleep_i,
  input  logic [OFF_W-1:0] off_ext_i,
  output logic [3:0]       gate_o,
  output logic [1:0]       decay_o
);
  chop_state_e state_q, state_d;
  logic dir_q, slow_q;
  logic blank_start, blank_open, off_start, off_last, off_fast;
  logic fault_q, fault_next, ext_sel, slow_sel;
  decay_e decay;

  assign ext_sel  = (mode_i == 2'b10) || (mode_i == 2'b11);
  assign slow_sel = full_step_i && ((mode_i == 2'b00) || (mode_i == 2'b01));

  chop_fault u_fault (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .short_i      (gnd_short_i),
    .sleep_i      (sleep_i),
    .fault_o      (fault_q),
    .fault_next_o (fault_next)
  );

  chop_blank #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (blank_start),
    .run_i   (state_q == ST_ON),
    .open_o  (blank_open)
  );

  chop_offtimer #(.OFF_W(OFF_W), .OFF_CYCLES_DEFAULT(OFF_CYCLES_DEFAULT)) u_off (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (off_start),
    .run_i     (state_q == ST_OFF),
    .ext_sel_i (ext_sel),
    .off_ext_i (off_ext_i),
    .last_o    (off_last),
    .fast_o    (off_fast)
  );

  always_comb begin
    state_d     = state_q;
    blank_start = 1'b0;
    off_start   = 1'b0;
    if (sleep_i || fault_next) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d     = ST_ON;
          blank_start = 1'b1;
        end
        ST_ON: if (blank_open && trip_i) begin
          state_d   = ST_OFF;
          off_start = 1'b1;
        end
        ST_OFF: if (off_last) begin
          state_d     = ST_ON;
          blank_start = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      slow_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (blank_start) dir_q  <= dir_i;
      if (off_start)   slow_q <= slow_sel;
    end
  end

  chop_bridge u_bridge (
    .state_i     (state_q),
    .dir_i       (dir_q),
    .fast_i      (off_fast),
    .slow_only_i (slow_q),
    .sleep_i     (sleep_i),
    .fault_i     (fault_q),
    .gate_o      (gate_o),
    .decay_o     (decay)
  );

  assign decay_o = decay;

  AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[3] && gate_o[2]) && !(gate_o[1] && gate_o[0]));  // R11
  AST_SLEEP_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (gate_o == 4'b0000 && decay_o == 2'b00));  // R10
  AST_FAULT_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> gate_o == 4'b0000);  // R8
  AST_BLANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && !blank_open && !sleep_i && !fault_next) |=> state_q == ST_ON);  // R3
  AST_FULLSTEP_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && slow_q && !sleep_i && !fault_q) |-> decay_o == 2'b10);  // R6
  AST_DIR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && $past(state_q) == ST_ON) |-> $stable(dir_q));  // R2
endmodule

// File: tb/chopper_ctrl_tb_top.sv
module chopper_ctrl_tb_top;
  localparam int BLANK = 6;
  localparam int DEFL  = 30;
  localparam int OW    = 8;

  logic clk_i = 1'b0;
  logic rst_ni, trip_i, full_step_i, gnd_short_i, dir_i, sleep_i;
  logic [1:0] mode_i;
  logic [OW-1:0] off_ext_i;
  logic [3:0] gate_o;
  logic [1:0] decay_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic cur_dir;

  always #2 clk_i = ~clk_i;

  chopper_ctrl #(.BLANK_CYCLES(BLANK), .OFF_CYCLES_DEFAULT(DEFL), .OFF_W(OW)) dut_i (
    .clk_i, .rst_ni, .trip_i, .mode_i, .full_step_i, .gnd_short_i,
    .dir_i, .sleep_i, .off_ext_i, .gate_o, .decay_o
  );

  function automatic logic [3:0] exp_drive(input logic d);
    return d ? 4'b1001 : 4'b0110;
  endfunction

  function automatic int exp_len(input logic [1:0] m, input int ext);
    if (m[1]) return (ext == 0) ? 1 : ext;
    return DEFL;
  endfunction

  function automatic logic [3:0] exp_off_gate(input logic d, input int i, input int len, input logic slow);
    if (slow || i >= len / 3) return d ? 4'b0001 : 4'b0100;
    return d ? 4'b0110 : 4'b1001;
  endfunction

  function automatic logic [1:0] exp_off_dcy(input int i, input int len, input logic slow);
    return (slow || i >= len / 3) ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // entry: at a negedge in on-phase cycle 0 with direction cur_dir
  task automatic run_phase(input logic nd, input logic [1:0] m, input logic fs,
                           input int ext, input int trip_at, input int bp, input logic hold);
    int len;
    logic slow;
    string tg;
    mode_i = m; full_step_i = fs; off_ext_i = OW'(ext); trip_i = hold;
    len  = exp_len(m, ext);
    slow = fs & ~m[1];
    for (int k = 0; k <= trip_at; k++) begin
      if (k > 0 && k - 1 == bp) tg = "R3";
      else if (k >= 2)          tg = "R2";
      else                      tg = "R1";
      chk(tg, gate_o, exp_drive(cur_dir));
      chk("R1", decay_o, 2'b00);
      if (k == 1) dir_i = nd;
      if (!hold) trip_i = (k == trip_at) || (k == bp);
      @(negedge clk_i);
    end
    trip_i = hold;
    for (int i = 0; i < len; i++) begin
      tg = slow ? "R6" : "R5";
      if (i == 0) tg = "R3";
      chk(tg, gate_o, exp_off_gate(cur_dir, i, len, slow));
      chk(slow ? "R6" : "R5", decay_o, exp_off_dcy(i, len, slow));
      @(negedge clk_i);
    end
    chk(hold ? "R7" : "R4", gate_o, exp_drive(nd));
    cur_dir = nd;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_c40f));
    rst_ni = 1'b0; trip_i = 1'b0; mode_i = 2'b00; full_step_i = 1'b0;
    gnd_short_i = 1'b0; dir_i = 1'b1; sleep_i = 1'b0; off_ext_i = 8'd10;
    repeat (3) @(negedge clk_i);
    chk("R1", gate_o, 4'b0000);
    chk("R1", decay_o, 2'b00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cur_dir = 1'b1;
    chk("R1", gate_o, 4'b1001);

    // directed corners
    run_phase(1'b0, 2'b00, 1'b0, 10, BLANK, 2, 1'b0);     // default mixed
    run_phase(1'b1, 2'b01, 1'b1, 10, BLANK + 3, 0, 1'b0); // full step slow
    run_phase(1'b1, 2'b10, 1'b1, 9, BLANK, -1, 1'b0);     // ext ignores full step (R6)
    run_phase(1'b0, 2'b11, 1'b0, 0, BLANK, 5, 1'b0);      // ext 0 -> 1 cycle
    run_phase(1'b0, 2'b00, 1'b0, 0, BLANK, -1, 1'b1);     // shorted load R7
    run_phase(1'b1, 2'b10, 1'b0, 4, BLANK, -1, 1'b1);     // R7 again
    trip_i = 1'b0;

    // constrained random
    for (int it = 0; it < 40; it++) begin
      logic [1:0] m;
      int ext, ta, bp;
      m   = 2'($urandom % 4);
      ext = int'($urandom % 40);
      ta  = BLANK + int'($urandom % 5);
      bp  = ($urandom % 2 == 1) ? int'($urandom % BLANK) : -1;
      run_phase(1'($urandom % 2), m, 1'($urandom % 2), ext, ta, bp, 1'b0);
    end

    // ground short latch, cleared by wake
    @(negedge clk_i);
    gnd_short_i = 1'b1;
    @(negedge clk_i);
    gnd_short_i = 1'b0;
    chk("R8", gate_o, 4'b0000);
    for (int i = 0; i < 15; i++) begin
      trip_i = 1'($urandom % 2); dir_i = 1'($urandom % 2); mode_i = 2'($urandom % 4);
      @(negedge clk_i);
      chk("R8", gate_o, 4'b0000);
    end
    trip_i = 1'b0;
    sleep_i = 1'b1;
    #1 chk("R10", gate_o, 4'b0000);
    repeat (2) @(negedge clk_i);
    dir_i = 1'b1; sleep_i = 1'b0;
    @(negedge clk_i);
    chk("R9", gate_o, 4'b1001);
    cur_dir = 1'b1;

    // sleep mid on-phase, short ignored while asleep
    @(negedge clk_i);
    sleep_i = 1'b1;
    #1 chk("R10", gate_o, 4'b0000);
    chk("R10", decay_o, 2'b00);
    @(negedge clk_i);
    gnd_short_i = 1'b1; trip_i = 1'b1;
    @(negedge clk_i);
    gnd_short_i = 1'b0; trip_i = 1'b0;
    chk("R10", gate_o, 4'b0000);
    @(negedge clk_i);
    dir_i = 1'b0; sleep_i = 1'b0;
    @(negedge clk_i);
    chk("R10", gate_o, 4'b0110);
    cur_dir = 1'b0;

    // reset clears fault
    gnd_short_i = 1'b1;
    @(negedge clk_i);
    gnd_short_i = 1'b0;
    chk("R8", gate_o, 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 chk("R8", gate_o, 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8", gate_o, exp_drive(dir_i));
    cur_dir = dir_i;
    run_phase(1'b1, 2'b00, 1'b0, 0, BLANK, -1, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule